// File: doc/BRIEF.md
# Two-Minute Decimal Stopwatch Counter

This block keeps elapsed time as three cascaded decimal digits: a one-bit minutes digit, a three-bit tens-of-seconds digit and a four-bit units-of-seconds digit. The displayed time runs from 0:00 to 1:59. On the next counting step after 1:59 it goes back to 0:00, and a one-cycle wrap pulse marks that step.

Every digit is a register with its own +1 adder and a select that loads either the incremented value or zero. A digit advances only on a counting step, and only while every less significant digit sits at its terminal value. The per-digit enables therefore ripple combinationally down the chain. The tick enable comes from an external one-second strobe. A run level gates counting, and a synchronous clear input zeroes the time.

Top module: `stopwatch_top`

## Requirements
- R1: After asynchronous reset (rst_ni low), secs_o, tens_o and mins_o are all 0 and wrap_o is 0.
- R2: A counting step happens on a rising clock edge where tick_i=1, run_i=1 and clear_i=0. Each counting step advances the displayed time by one second, with secs_o in the range 0..9, tens_o in the range 0..5 and mins_o in the range 0..1.
- R3: secs_o steps from 9 to 0 on a counting step, and tens_o increments on that same step.
- R4: tens_o steps from 5 to 0 when secs_o=9 on a counting step, and mins_o increments on that same step.
- R5: The counting step taken at 1:59 returns all three digits to 0:00.
- R6: wrap_o is 1 for exactly the one cycle after the step from 1:59 to 0:00, and 0 at all other times.
- R7: While run_i=0, or while tick_i=0, all digits keep their values.
- R8: clear_i=1 zeroes all digits on the next edge, whether run_i is high or low. Clear overrides a tick arriving in the same cycle, and no wrap_o pulse is produced.
- R9: No digit ever leaves its legal range (secs_o ≤ 9, tens_o ≤ 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| run_i | input | 1 | Run level: high counts, low holds |
| clear_i | input | 1 | Synchronous clear to 0:00 |
| secs_o | output | 4 | Units-of-seconds digit |
| tens_o | output | 3 | Tens-of-seconds digit |
| mins_o | output | 1 | Minutes digit |
| wrap_o | output | 1 | One-cycle pulse after the 1:59 to 0:00 step |

## Verification
Two functions can fall in the same cycle: clear and a counting tick, including a tick at 1:59 that would otherwise wrap. The bench drives both at once, at mid-count and at 1:59, and expects 0:00 with no wrap pulse. It also sweeps all 120 states against a seconds counter and holds the ticks while run is low.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int unsigned SecsW = 4;
  localparam int unsigned TensW = 3;
  localparam int unsigned MinsW = 1;
  localparam int unsigned SecsLast = 9;
  localparam int unsigned TensLast = 5;
  localparam int unsigned MinsLast = 1;
endpackage

// File: rtl/sw_digit.sv
module sw_digit #(
  parameter int unsigned W    = 4,
  parameter int unsigned LAST = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] q_o,
  output logic         term_o
);
  localparam logic [W-1:0] LastV = W'(LAST);
  logic [W-1:0] inc;
  logic [W-1:0] nxt;

  assign inc    = q_o + W'(1);
  assign term_o = (q_o == LastV);
  // zero select covers both clear and wrap
  assign nxt    = (clr_i || term_o) ? '0 : inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q_o <= '0;
    else if (clr_i || en_i)    q_o <= nxt;
  end

  a_r9_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o <= LastV);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/stopwatch_top.sv
module stopwatch_top
  import stopwatch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clear_i,
  output logic [SecsW-1:0] secs_o,
  output logic [TensW-1:0] tens_o,
  output logic [MinsW-1:0] mins_o,
  output logic             wrap_o
);
  logic step, secs_t, tens_t, mins_t;
  logic en_tens, en_mins;

  assign step    = tick_i & run_i & ~clear_i;
  assign en_tens = step & secs_t;
  assign en_mins = en_tens & tens_t;

  sw_digit #(.W(SecsW), .LAST(SecsLast)) u_secs (
    .clk_i, .rst_ni, .clr_i(clear_i), .en_i(step),
    .q_o(secs_o), .term_o(secs_t));
  sw_digit #(.W(TensW), .LAST(TensLast)) u_tens (
    .clk_i, .rst_ni, .clr_i(clear_i), .en_i(en_tens),
    .q_o(tens_o), .term_o(tens_t));
  sw_digit #(.W(MinsW), .LAST(MinsLast)) u_mins (
    .clk_i, .rst_ni, .clr_i(clear_i), .en_i(en_mins),
    .q_o(mins_o), .term_o(mins_t));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wrap_o <= 1'b0;
    else         wrap_o <= en_mins & mins_t;
  end

  a_r3_secs_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && secs_o == 4'd9 && tens_o != 3'd5) |=> (secs_o == 0 && tens_o == $past(tens_o) + 3'd1));
  a_r5_full_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && mins_o == 1'b1 && tens_o == 3'd5 && secs_o == 4'd9) |=> (mins_o == 0 && tens_o == 0 && secs_o == 0));
  a_r6_wrap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (secs_o == 0 && tens_o == 0 && mins_o == 0));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (secs_o == 0 && tens_o == 0 && mins_o == 0 && !wrap_o));
endmodule

// File: tb/sim_stopwatch_top.sv
`timescale 1ns/1ps
module sim_stopwatch_top;
  logic clk = 0, rst_n = 0, tick = 0, run = 0, clr = 0;
  logic [3:0] secs; logic [2:0] tens; logic [0:0] mins; logic wrap;
  int errs = 0, checks = 0, ref_s = 0;

  always #4 clk = ~clk;

  stopwatch_top u0 (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run),
    .clear_i(clr), .secs_o(secs), .tens_o(tens), .mins_o(mins), .wrap_o(wrap));

  task automatic chk(string req, int exp_s, logic exp_w);
    int act;
    act = int'(mins) * 60 + int'(tens) * 10 + int'(secs);
    checks++;
    if (act != exp_s || wrap !== exp_w || secs > 9 || tens > 5) begin
      errs++;
      $display("FAIL %s: got %0d:%0d%0d wrap=%0b, expected %0d wrap=%0b",
               req, mins, tens, secs, wrap, exp_s, exp_w);
    end
  endtask

  task automatic cyc(logic t, logic r, logic c);
    tick = t; run = r; clr = c;
    @(posedge clk); #1;
    tick = 0; clr = 0;
  endtask

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #20; chk("R1 reset", 0, 0);
    rst_n = 1; @(posedge clk); #1;
    // R2 R3 R4 R5 R6: full sweep of 120 states plus wrap
    for (int i = 0; i < 125; i++) begin
      cyc(1, 1, 0);
      ref_s = (ref_s + 1) % 120;
      chk("R2 R3 R4 R5 R6 sweep", ref_s, ref_s == 0);
      cyc(0, 1, 0);
      chk("R6 pulse one cycle", ref_s, 0);
    end
    // R7 hold while stopped
    for (int i = 0; i < 5; i++) begin cyc(1, 0, 0); chk("R7 stopped", ref_s, 0); end
    // R8 clear mid-count while stopped
    cyc(0, 0, 1); ref_s = 0; chk("R8 clear stopped", 0, 0);
    for (int i = 0; i < 37; i++) begin cyc(1, 1, 0); ref_s++; end
    chk("R2 count 37", 37, 0);
    cyc(1, 1, 1); ref_s = 0; chk("R8 clear beats tick", 0, 0);
    for (int i = 0; i < 119; i++) cyc(1, 1, 0);
    chk("R2 at 1:59", 119, 0);
    cyc(1, 1, 1); chk("R8 clear at 1:59 no wrap", 0, 0);
    cyc(0, 1, 0); chk("R8 no late wrap", 0, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule